// File: doc/BRIEF.md
# Byte-Buffered Synchronous Serial Port

This block is one channel of a synchronous serial link: a serial clock line, a data input, a data output and an active-low chip select. An eight-entry byte store stands behind the shifter. Software fills the entries, states how many bytes to move (one to eight), and pulses start. The block then shifts the whole run without any help per byte. Each received byte overwrites the entry that was just sent, so when the run ends the store holds the incoming data.

The serial clock is either made inside the block from the system clock (master) or taken from the clock input pin (slave). In chip-select mode the chip select gates the serial activity. While it is high, the clock and data-out drivers are released and no bit moves. If it rises part way through a byte, that byte starts again from its first bit. A sticky done flag and a one-cycle interrupt pulse mark the end of the run.

Top module: `sio_fifo_port`

## Requirements
- R1: After reset, busy, done and irq are low, sck_o and sdo_o are high, and every store entry reads 8'h00.
- R2: With busy low, a host_we cycle writes host_wdata into the entry at host_addr, and host_rdata shows the entry at host_addr combinationally. Host writes made while busy is high are ignored.
- R3: A start with xfer_len = n moves entries 0 to n in ascending order (n+1 bytes). Entries above n are left untouched.
- R4: Bytes go out most significant bit first. sdo_o changes only at a falling serial clock edge, and sdi is sampled at the rising edge.
- R5: Each byte received replaces the store entry that was transmitted in the same byte slot.
- R6: In master mode sck_o idles high and toggles every SCK_HALF system clocks while a run is in progress, giving a period of 2*SCK_HALF. sck_oe is high in master mode whenever chip select does not gate it.
- R7: In slave mode sck_oe stays low, and bits advance only on edges of sck_i.
- R8: With cs_mode high and cs_n high, sck_oe and sdo_oe are low and no bit advances. With cs_mode low, sdo_oe is always high.
- R9: If cs_n goes high in the middle of a byte in cs_mode, the partial byte is discarded. When cs_n returns low, the same entry is sent again from its most significant bit.
- R10: When the last byte of a run completes, busy falls, done rises and irq pulses for exactly one cycle. The next start clears done. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Store write strobe |
| host_addr | input | IDX_W | Store entry index for read and write |
| host_wdata | input | DATA_W | Store write data |
| host_rdata | output | DATA_W | Store entry at host_addr |
| xfer_len | input | IDX_W | Byte count minus one, captured at start |
| start | input | 1 | Begin a run (ignored while busy) |
| master | input | 1 | 1: internal serial clock, 0: external |
| cs_mode | input | 1 | 1: chip select gates the transfer |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky end-of-run flag |
| irq | output | 1 | One-cycle end-of-run pulse |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Generated serial clock (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| sdi | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data driver enable |
| cs_n | input | 1 | Active-low chip select |

## Verification
The assertions assume that master and cs_mode stay constant during a run. They also assume that sck_i, sdi and cs_n change slowly compared with the synchronizer depth, so that no edge of sck_i is lost and sdi is settled when the synchronized rising edge arrives. The bench changes the mode inputs only while the port is idle. It drives sdi one bit after each falling edge, and in slave mode it holds each half-period of sck_i for eight system clocks. This is well above the two-stage synchronizer delay.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_FALL = 2'd1,
      EV_RISE = 2'd2
   } sck_ev_e;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_one
         logic st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= RST_VAL;
            else        st <= d;
         end
         assign q = st;
      end else begin : g_chain
         logic [STAGES-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= {STAGES{RST_VAL}};
            else        st <= {st[STAGES-2:0], d};
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
   import sio_pkg::*;
#(
   parameter int SCK_HALF = 4
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    run,
   output logic    sck,
   output sck_ev_e ev
);
   localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
   localparam logic [DW-1:0] LAST = DW'(SCK_HALF - 1);

   logic [DW-1:0] div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div <= '0;
         sck <= 1'b1;
      end else if (!run) begin
         div <= '0;
         sck <= 1'b1;
      end else if (div == LAST) begin
         div <= '0;
         sck <= ~sck;
      end else begin
         div <= div + 1'b1;
      end
   end

   always_comb begin
      ev = EV_NONE;
      if (run && div == LAST) ev = sck ? EV_FALL : EV_RISE;
   end
endmodule

// File: rtl/sio_store.sv
module sio_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [IDX_W-1:0]  raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] ent [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           ent[g] <= '0;
            else if (we && waddr == IDX_W'(g))    ent[g] <= wdata;
         end
      end
   endgenerate

   assign rdata_a = ent[raddr_a];
   assign rdata_b = ent[raddr_b];
endmodule

// File: rtl/sio_fifo_port.sv
module sio_fifo_port
   import sio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 8,
   parameter int SCK_HALF    = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(DEPTH),
   localparam int BIT_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [IDX_W-1:0]  xfer_len,
   input  logic              start,
   input  logic              master,
   input  logic              cs_mode,
   output logic              busy,
   output logic              done,
   output logic              irq,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              sdi,
   output logic              sdo_o,
   output logic              sdo_oe,
   input  logic              cs_n
);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 2 || (1 << BIT_W) != DATA_W) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 2");
      end
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (SCK_HALF < SYNC_STAGES + 2) begin : g_bad_half
         $error("SCK_HALF must exceed the synchronizer depth by two");
      end
   endgenerate

   logic cs_s, sck_s, sdi_s, sck_p;
   sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync
      (.clk(clk), .rst_n(rst_n), .d(cs_n),  .q(cs_s));
   sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sck_sync
      (.clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
   sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sdi_sync
      (.clk(clk), .rst_n(rst_n), .d(sdi),   .q(sdi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_p <= 1'b1;
      else        sck_p <= sck_s;
   end

   // chip-select gating of bit progress
   logic cs_ok, abort;
   assign cs_ok = !cs_mode || !cs_s;
   assign abort = busy && !cs_ok;

   // serial clock source selection
   logic    sck_m;
   sck_ev_e ev_m, ev_s, ev;
   sio_clkgen #(.SCK_HALF(SCK_HALF)) i_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy && master && cs_ok),
      .sck(sck_m), .ev(ev_m)
   );

   always_comb begin
      ev_s = EV_NONE;
      if (sck_p && !sck_s)      ev_s = EV_FALL;
      else if (!sck_p && sck_s) ev_s = EV_RISE;
      ev = EV_NONE;
      if (busy && cs_ok) ev = master ? ev_m : ev_s;
   end

   // byte store
   logic [IDX_W-1:0]  idx, cnt_q;
   logic [BIT_W-1:0]  bit_cnt;
   logic [DATA_W-2:0] rx_sh;
   logic [DATA_W-1:0] tx_byte, st_wdata;
   logic [IDX_W-1:0]  st_waddr;
   logic              st_we, byte_end;

   assign byte_end = (ev == EV_RISE) && (bit_cnt == LAST_BIT);

   always_comb begin
      st_we    = 1'b0;
      st_waddr = host_addr;
      st_wdata = host_wdata;
      if (busy) begin
         st_we    = byte_end;
         st_waddr = idx;
         st_wdata = {rx_sh, sdi_s};
      end else begin
         st_we    = host_we;
      end
   end

   sio_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
      .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
      .raddr_a(host_addr), .rdata_a(host_rdata),
      .raddr_b(idx), .rdata_b(tx_byte)
   );

   // run sequencing
   logic sdo_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         irq     <= 1'b0;
         idx     <= '0;
         cnt_q   <= '0;
         bit_cnt <= '0;
         rx_sh   <= '0;
         sdo_q   <= 1'b1;
      end else begin
         irq <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy    <= 1'b1;
               done    <= 1'b0;
               idx     <= '0;
               bit_cnt <= '0;
               cnt_q   <= xfer_len;
            end
         end else if (abort) begin
            bit_cnt <= '0;
         end else begin
            case (ev)
               EV_FALL: sdo_q <= tx_byte[LAST_BIT - bit_cnt];
               EV_RISE: begin
                  rx_sh <= {rx_sh[DATA_W-3:0], sdi_s};
                  if (bit_cnt == LAST_BIT) begin
                     bit_cnt <= '0;
                     if (idx == cnt_q) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        irq  <= 1'b1;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sck_o  = sck_m;
   assign sdo_o  = sdo_q;
   assign sdo_oe = !cs_mode || !cs_n;
   assign sck_oe = master && (!cs_mode || !cs_n);
endmodule

// File: rtl/sio_fifo_port_chk.sv
module sio_fifo_port_chk (
   input logic clk,
   input logic rst_n,
   input logic master,
   input logic cs_mode,
   input logic cs_n,
   input logic busy,
   input logic done,
   input logic irq,
   input logic sck_o,
   input logic sck_oe,
   input logic sdo_o,
   input logic sdo_oe
);
   p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done && !busy));

   p_done_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !done);

   p_sck_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_o);

   p_slave_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !master |-> !sck_oe);

   p_cs_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_mode && cs_n) |-> (!sck_oe && !sdo_oe));

   p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (master && $past(master) && !$stable(sdo_o)) |-> $fell(sck_o));
endmodule

bind sio_fifo_port sio_fifo_port_chk i_chk (
   .clk(clk), .rst_n(rst_n), .master(master), .cs_mode(cs_mode), .cs_n(cs_n),
   .busy(busy), .done(done), .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe),
   .sdo_o(sdo_o), .sdo_oe(sdo_oe)
);

// File: tb/test_sio_fifo_port.sv
module test_sio_fifo_port;
   localparam int CLK_PERIOD = 10;
   localparam int SCK_HALF   = 4;
   localparam int SLV_HALF   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [2:0] xfer_len = '0;
   logic       start = 1'b0, master = 1'b0, cs_mode = 1'b0;
   logic       busy, done, irq;
   logic       sck_i = 1'b1, sck_o, sck_oe;
   logic       sdi = 1'b0, sdo_o, sdo_oe;
   logic       cs_n = 1'b1;

   int checks = 0;
   int errors = 0;

   logic [7:0] model  [8];
   logic [7:0] tx_exp [8];
   logic [7:0] rx_pat [8];
   logic [7:0] got    [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_fifo_port #(.DATA_W(8), .DEPTH(8), .SCK_HALF(SCK_HALF), .SYNC_STAGES(2)) i_sio_fifo_port (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .xfer_len(xfer_len),
      .start(start), .master(master), .cs_mode(cs_mode), .busy(busy), .done(done),
      .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi),
      .sdo_o(sdo_o), .sdo_oe(sdo_oe), .cs_n(cs_n)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input int a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = 3'(a); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic check_store(input string req);
      for (int a = 0; a < 8; a++) begin
         host_addr = 3'(a);
         #1;
         check(host_rdata == model[a], req, $sformatf("entry %0d", a), host_rdata, model[a]);
      end
   endtask

   task automatic kick(input int nbytes);
      @(negedge clk);
      start = 1'b1; xfer_len = 3'(nbytes - 1);
      @(negedge clk);
      start = 1'b0;
   endtask

   // external slave model for master-mode runs
   task automatic master_run(input int nbytes, input bit inject);
      int falls = 0, rises = 0, cyc = 0, last_fall = -1;
      int bad_per = 0, irqs = 0, oe_bad = 0;
      logic prev_sck = 1'b1;
      for (int b = 0; b < 8; b++) got[b] = 8'h00;
      while (busy && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (inject && cyc == 20) begin
            host_we = 1'b1; host_addr = 3'd7; host_wdata = 8'hEE;
            start = 1'b1; xfer_len = 3'd7;
         end
         if (inject && cyc == 21) begin
            host_we = 1'b0; start = 1'b0;
         end
         if (irq) irqs++;
         if (!sck_oe || !sdo_oe) oe_bad++;
         if (prev_sck && !sck_o) begin
            if (last_fall >= 0 && cyc - last_fall != 2*SCK_HALF) bad_per++;
            last_fall = cyc;
            if (falls < 64) sdi = rx_pat[falls/8][7 - (falls%8)];
            falls++;
         end
         if (!prev_sck && sck_o) begin
            if (rises < 64) got[rises/8][7 - (rises%8)] = sdo_o;
            rises++;
         end
         prev_sck = sck_o;
      end
      check(rises == nbytes*8, "R3", "bits moved", rises, nbytes*8);
      for (int b = 0; b < nbytes; b++)
         check(got[b] == tx_exp[b], "R4", $sformatf("byte %0d sent msb first", b), got[b], tx_exp[b]);
      check(bad_per == 0, "R6", "sck period errors", bad_per, 0);
      check(oe_bad == 0, "R6", "driver enable drops", oe_bad, 0);
      check(irqs == 1, "R10", "irq pulses", irqs, 1);
      check(done == 1'b1, "R10", "done after run", done, 1);
      @(negedge clk);
      check(irq == 1'b0, "R10", "irq one cycle", irq, 0);
      for (int b = 0; b < nbytes; b++) model[b] = rx_pat[b];
   endtask

   task automatic slave_bit(input logic din, output logic dout);
      @(negedge clk);
      sck_i = 1'b0; sdi = din;
      repeat (SLV_HALF) @(negedge clk);
      dout = sdo_o; sck_i = 1'b1;
      repeat (SLV_HALF) @(negedge clk);
   endtask

   task automatic slave_byte(input logic [7:0] din, output logic [7:0] dout);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         slave_bit(din[i], b);
         dout[i] = b;
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !irq, "R1", "busy/done/irq", {busy, done, irq}, 0);
      check(sck_o && sdo_o, "R1", "sck_o/sdo_o idle", {sck_o, sdo_o}, 3);
      for (int a = 0; a < 8; a++) model[a] = 8'h00;
      check_store("R1");
   endtask

   task automatic t_host_rw;
      for (int a = 0; a < 8; a++) begin
         model[a] = 8'(8'h3C + a * 8'h27);
         host_write(a, model[a]);
      end
      check_store("R2");
   endtask

   task automatic t_master_full;
      master = 1'b1; cs_mode = 1'b0;
      for (int b = 0; b < 8; b++) begin
         tx_exp[b] = model[b];
         rx_pat[b] = 8'(8'hA1 ^ (b * 8'h1D));
      end
      kick(8);
      master_run(8, 1'b0);
      check_store("R5");
   endtask

   task automatic t_master_short;
      for (int b = 0; b < 3; b++) begin
         tx_exp[b] = model[b];
         rx_pat[b] = 8'(8'h96 + b * 8'h13);
      end
      kick(3);
      check(done == 1'b0, "R10", "start clears done", done, 0);
      master_run(3, 1'b1);
      check_store("R3");
      host_addr = 3'd7; #1;
      check(host_rdata == model[7], "R2", "write while busy ignored", host_rdata, model[7]);
   endtask

   task automatic t_cs_gate;
      int toggles = 0;
      logic prev;
      master = 1'b1; cs_mode = 1'b1; cs_n = 1'b1;
      tx_exp[0] = model[0];
      rx_pat[0] = 8'h4E;
      kick(1);
      prev = sck_o;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (sck_o != prev) toggles++;
         prev = sck_o;
      end
      check(!sck_oe && !sdo_oe, "R8", "drivers released", {sck_oe, sdo_oe}, 0);
      check(toggles == 0, "R8", "sck toggles while deselected", toggles, 0);
      check(busy == 1'b1, "R8", "run held", busy, 1);
      cs_n = 1'b0;
      @(negedge clk);
      check(sck_oe && sdo_oe, "R8", "drivers enabled", {sck_oe, sdo_oe}, 3);
      master_run(1, 1'b0);
      check_store("R8");
      cs_mode = 1'b0;
      @(negedge clk);
      cs_n = 1'b1;
      @(negedge clk);
      check(sdo_oe == 1'b1, "R8", "sdo_oe without cs mode", sdo_oe, 1);
   endtask

   task automatic t_slave;
      logic [7:0] o0, o1;
      master = 1'b0; cs_mode = 1'b0;
      kick(2);
      check(sck_oe == 1'b0, "R7", "sck_oe in slave", sck_oe, 0);
      repeat (30) @(negedge clk);
      check(busy == 1'b1, "R7", "no progress without sck_i", busy, 1);
      slave_byte(8'h3B, o0);
      slave_byte(8'hC4, o1);
      repeat (5) @(negedge clk);
      check(o0 == model[0], "R7", "slave byte 0 out", o0, model[0]);
      check(o1 == model[1], "R4", "slave byte 1 out", o1, model[1]);
      check(done && !busy, "R10", "slave run done", {done, busy}, 2);
      model[0] = 8'h3B; model[1] = 8'hC4;
      check_store("R5");
   endtask

   task automatic t_cs_abort;
      logic b;
      logic [7:0] o;
      master = 1'b0; cs_mode = 1'b1; cs_n = 1'b0;
      repeat (4) @(negedge clk);
      kick(1);
      for (int i = 0; i < 4; i++) slave_bit(1'b1, b);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      check(sdo_oe == 1'b0, "R8", "sdo released mid byte", sdo_oe, 0);
      for (int i = 0; i < 3; i++) slave_bit(1'b0, b);
      check(busy == 1'b1, "R9", "busy after abort", busy, 1);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      slave_byte(8'h5A, o);
      repeat (5) @(negedge clk);
      check(o == model[0], "R9", "byte resent from msb", o, model[0]);
      check(done == 1'b1, "R9", "done after full byte", done, 1);
      model[0] = 8'h5A;
      check_store("R9");
   endtask

   initial begin
      t_reset();
      t_host_rw();
      t_master_full();
      t_master_short();
      t_cs_gate();
      t_slave();
      t_cs_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule